// File: doc/BRIEF.md
# Memory-Operand Shift and Digit-Rotate Unit

This unit is the datapath that a CPU core uses to shift, rotate or digit-rotate an operand that has already been read from memory. The core supplies four inputs for each operation: an operation code, a byte/word size select, the loaded operand, and the current carry flag. The two digit rotates also take the accumulator. The unit returns the value to store back to memory, the new accumulator value, the six condition flags, a write-enable for each flag, and the number of execution cycles the core must charge for the operation.

The logic is combinational and is followed by one output register. A request presented with `valid_i` in one cycle therefore appears on the outputs, with `valid_o` high, after the next rising clock edge. Instruction decode, address generation and the memory access itself belong to the surrounding core.

Top module: `mem_shift_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, with no request issued, `valid_o`, `wdata_o`, `acc_o`, `flags_o`, `flag_we_o` and `cycles_o` are all zero.
- R2: A request with `valid_i` high and `op_i` in 0..9 produces `valid_o` high exactly one clock later. `op_i` values 10..15, or `valid_i` low, produce `valid_o` low in that cycle.
- R3: Operation codes are 0 rotate-left-circular, 1 rotate-right-circular, 2 rotate-left-through-carry, 3 rotate-right-through-carry, 4 arithmetic-shift-left, 5 arithmetic-shift-right, 6 logical-shift-left, 7 logical-shift-right, 8 digit-rotate-left, 9 digit-rotate-right. For shifts and rotates, `word_i`=0 works on `mem_i[7:0]` and forces `wdata_o[15:8]` to zero, while `word_i`=1 works on all 16 bits.
- R4: The circular rotates move the bit that leaves one end into the other end and also copy it into C.
- R5: The through-carry rotates place `carry_i` in the vacated end bit and load C from the bit shifted out. Their flag write-enables leave H and N unwritten (`flag_we_o` = 6'b110101).
- R6: Both left shifts fill bit 0 with zero and load C from the old MSB. The arithmetic right shift keeps the sign bit, the logical right shift inserts zero, and both load C from bit 0.
- R7: For every shift and rotate, S is the result MSB (bit 7 for byte, bit 15 for word), Z is set for a zero result, V is 1 when the result has an even number of ones, H and N are 0, and `cycles_o` is 8.
- R8: Digit-rotate-left returns accumulator {acc[7:4], mem[7:4]} and memory value {mem[3:0], acc[3:0]}.
- R9: Digit-rotate-right returns accumulator {acc[7:4], mem[3:0]} and memory value {acc[3:0], mem[7:4]}.
- R10: Both digit rotates take S from the new accumulator bit 7, set Z when the new accumulator is zero, set V from the even parity of the new accumulator, clear H and N, leave C unwritten (`flag_we_o` = 6'b111110), report 12 cycles, ignore `word_i`, and keep `wdata_o[15:8]` at zero.
- R11: `flags_o` and `flag_we_o` both use the bit order [5]=S, [4]=Z, [3]=H, [2]=V, [1]=N, [0]=C. A flag whose write-enable is 0 is driven as 0. Shifts and rotates return `acc_i` unchanged on `acc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| mem_i | input | 16 | Operand loaded from memory |
| carry_i | input | 1 | Current carry flag |
| acc_i | input | 8 | Current accumulator |
| valid_o | output | 1 | Result valid, one cycle after the request |
| wdata_o | output | 16 | Value to write back to memory |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 6 | New flag values {S,Z,H,V,N,C} |
| flag_we_o | output | 6 | Per-flag write enables, same order as `flags_o` |
| cycles_o | output | 5 | Execution cycle count |

## Verification
The unit holds no state between requests other than its output register, so any fault becomes visible in the single cycle after the request that triggers it. Examples of such faults are a wrong operation selection, a stale size select, or a carry taken from the wrong end. In that cycle the fault shows up as a wrong written-back value, a wrong flag, or a wrong enable mask. Because of this, comparing every output against an independent model on every clock, across all ten operations, both sizes and both carry values, exposes a fault on the first request that exercises it.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int DATA_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;
  localparam int CYC_W     = 5;
  localparam int FLAG_N    = 6;
  localparam int SHIFT_CYC = 8;
  localparam int DIGIT_CYC = 12;

  // flag bit positions
  localparam int F_S = 5;
  localparam int F_Z = 4;
  localparam int F_H = 3;
  localparam int F_V = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  typedef enum logic [3:0] {
    OP_RLC = 4'd0,
    OP_RRC = 4'd1,
    OP_RL  = 4'd2,
    OP_RR  = 4'd3,
    OP_SLA = 4'd4,
    OP_SRA = 4'd5,
    OP_SLL = 4'd6,
    OP_SRL = 4'd7,
    OP_RLD = 4'd8,
    OP_RRD = 4'd9
  } msu_op_e;

  localparam logic [3:0] OP_LAST = 4'd9;
endpackage

// File: rtl/msu_shift.sv
module msu_shift
  import msu_pkg::*;
#(
  parameter int W = 8
) (
  input  msu_op_e        op_i,
  input  logic [W-1:0]   val_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic           cout_o
);
  always_comb begin
    res_o  = val_i;
    cout_o = cin_i;
    unique case (op_i)
      OP_RLC: begin res_o = {val_i[W-2:0], val_i[W-1]}; cout_o = val_i[W-1]; end
      OP_RRC: begin res_o = {val_i[0], val_i[W-1:1]};   cout_o = val_i[0];   end
      OP_RL:  begin res_o = {val_i[W-2:0], cin_i};      cout_o = val_i[W-1]; end
      OP_RR:  begin res_o = {cin_i, val_i[W-1:1]};      cout_o = val_i[0];   end
      OP_SLA,
      OP_SLL: begin res_o = {val_i[W-2:0], 1'b0};       cout_o = val_i[W-1]; end
      OP_SRA: begin res_o = {val_i[W-1], val_i[W-1:1]}; cout_o = val_i[0];   end
      OP_SRL: begin res_o = {1'b0, val_i[W-1:1]};       cout_o = val_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/msu_digit.sv
module msu_digit
  import msu_pkg::*;
(
  input  logic              right_i,
  input  logic [BYTE_W-1:0] mem_i,
  input  logic [BYTE_W-1:0] acc_i,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] mem_o
);
  localparam int HI = BYTE_W - 1;
  localparam int LO = NIB_W - 1;

  always_comb begin
    if (right_i) begin
      acc_o = {acc_i[HI:NIB_W], mem_i[LO:0]};
      mem_o = {acc_i[LO:0], mem_i[HI:NIB_W]};
    end else begin
      acc_o = {acc_i[HI:NIB_W], mem_i[HI:NIB_W]};
      mem_o = {mem_i[LO:0], acc_i[LO:0]};
    end
  end
endmodule

// File: rtl/mem_shift_unit.sv
module mem_shift_unit
  import msu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic              carry_i,
  input  logic [BYTE_W-1:0] acc_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] flag_we_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam int PAD_W = DATA_W - BYTE_W;
  localparam logic [FLAG_N-1:0] WE_ALL   = '1;
  localparam logic [FLAG_N-1:0] WE_NO_HN = ~((FLAG_N'(1) << F_H) | (FLAG_N'(1) << F_N));
  localparam logic [FLAG_N-1:0] WE_NO_C  = ~(FLAG_N'(1) << F_C);

  msu_op_e op;
  logic    legal, is_digit, keep_hn;
  assign op       = msu_op_e'(op_i);
  assign legal    = (op_i <= OP_LAST);
  assign is_digit = (op == OP_RLD) || (op == OP_RRD);
  assign keep_hn  = (op == OP_RL) || (op == OP_RR);

  logic [BYTE_W-1:0] res_b;
  logic [DATA_W-1:0] res_w;
  logic              cout_b, cout_w;

  msu_shift #(.W(BYTE_W)) u_shift_b (
    .op_i(op), .val_i(mem_i[BYTE_W-1:0]), .cin_i(carry_i), .res_o(res_b), .cout_o(cout_b)
  );
  msu_shift #(.W(DATA_W)) u_shift_w (
    .op_i(op), .val_i(mem_i), .cin_i(carry_i), .res_o(res_w), .cout_o(cout_w)
  );

  logic [BYTE_W-1:0] dig_acc, dig_mem;
  msu_digit u_digit (
    .right_i(op == OP_RRD), .mem_i(mem_i[BYTE_W-1:0]), .acc_i(acc_i),
    .acc_o(dig_acc), .mem_o(dig_mem)
  );

  logic [DATA_W-1:0] wdata_d;
  logic [BYTE_W-1:0] acc_d;
  logic [FLAG_N-1:0] flags_d, we_d;
  logic [CYC_W-1:0]  cyc_d;

  always_comb begin
    flags_d = '0;
    if (is_digit) begin
      wdata_d      = {{PAD_W{1'b0}}, dig_mem};
      acc_d        = dig_acc;
      flags_d[F_S] = dig_acc[BYTE_W-1];
      flags_d[F_Z] = (dig_acc == '0);
      flags_d[F_V] = ~^dig_acc;
      we_d         = WE_NO_C;
      cyc_d        = CYC_W'(DIGIT_CYC);
    end else begin
      wdata_d      = word_i ? res_w : {{PAD_W{1'b0}}, res_b};
      acc_d        = acc_i;
      flags_d[F_S] = word_i ? res_w[DATA_W-1] : res_b[BYTE_W-1];
      flags_d[F_Z] = (wdata_d == '0);
      flags_d[F_V] = ~^wdata_d;
      flags_d[F_C] = word_i ? cout_w : cout_b;
      we_d         = keep_hn ? WE_NO_HN : WE_ALL;
      cyc_d        = CYC_W'(SHIFT_CYC);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wdata_o   <= '0;
      acc_o     <= '0;
      flags_o   <= '0;
      flag_we_o <= '0;
      cycles_o  <= '0;
    end else begin
      valid_o <= valid_i && legal;
      if (valid_i && legal) begin
        wdata_o   <= wdata_d;
        acc_o     <= acc_d;
        flags_o   <= flags_d;
        flag_we_o <= we_d;
        cycles_o  <= cyc_d;
      end
    end
  end
endmodule

// File: rtl/msu_checker.sv
module msu_checker
  import msu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              word_i,
  input logic [DATA_W-1:0] mem_i,
  input logic              carry_i,
  input logic [BYTE_W-1:0] acc_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic [BYTE_W-1:0] acc_o,
  input logic [FLAG_N-1:0] flags_o,
  input logic [FLAG_N-1:0] flag_we_o,
  input logic [CYC_W-1:0]  cycles_o
);
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(valid_i) && ($past(op_i) <= OP_LAST)) |-> valid_o);

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(valid_i) && ($past(op_i) <= OP_LAST)));

  assert_byte_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (!$past(word_i) || $past(op_i) >= OP_RLD)) |-> (wdata_o[DATA_W-1:BYTE_W] == '0));

  assert_shift_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) < OP_RLD) |-> (flags_o[F_V] == ~^wdata_o && cycles_o == CYC_W'(SHIFT_CYC)));

  assert_carry_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(op_i) == OP_RL || $past(op_i) == OP_RR)) |-> (flag_we_o == 6'b110101));

  assert_digit_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) >= OP_RLD) |->
      (flags_o[F_V] == ~^acc_o && flag_we_o == 6'b111110 && cycles_o == CYC_W'(DIGIT_CYC)));

  assert_acc_high_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (acc_o[BYTE_W-1:NIB_W] == $past(acc_i[BYTE_W-1:NIB_W])));

  assert_masked_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((flags_o & ~flag_we_o) == '0));
endmodule

bind mem_shift_unit msu_checker u_chk (.*);

// File: tb/mem_shift_unit_test.sv
module mem_shift_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [3:0]  op_i;
  logic        word_i;
  logic [15:0] mem_i;
  logic        carry_i;
  logic [7:0]  acc_i;
  logic        valid_o;
  logic [15:0] wdata_o;
  logic [7:0]  acc_o;
  logic [5:0]  flags_o, flag_we_o;
  logic [4:0]  cycles_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  mem_shift_unit uut (.*);

  typedef struct {
    int vld; int op; int word; int wdata; int acc; int flags; int we; int cyc;
  } exp_t;
  exp_t q[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int even_par(int v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  function automatic exp_t model(int vld, int op, int word, int mem, int cin, int acc);
    exp_t e;
    int w, mask, v, msb, r, c, m;
    e.vld = (vld != 0 && op <= 9) ? 1 : 0;
    e.op = op; e.word = word;
    e.wdata = 0; e.acc = 0; e.flags = 0; e.we = 0; e.cyc = 0;
    if (op >= 8) begin
      m = mem & 'hFF;
      if (op == 8) begin
        e.acc   = (acc & 'hF0) | (m >> 4);
        e.wdata = ((m & 'hF) << 4) | (acc & 'hF);
      end else begin
        e.acc   = (acc & 'hF0) | (m & 'hF);
        e.wdata = ((acc & 'hF) << 4) | (m >> 4);
      end
      e.flags = (((e.acc >> 7) & 1) << 5) | ((e.acc == 0 ? 1 : 0) << 4) | (even_par(e.acc) << 2);
      e.we = 'b111110;
      e.cyc = 12;
    end else begin
      w = word ? 16 : 8;
      mask = (1 << w) - 1;
      v = mem & mask;
      msb = (v >> (w - 1)) & 1;
      case (op)
        0: begin c = msb;   r = ((v << 1) | msb) & mask; end
        1: begin c = v & 1; r = (v >> 1) | ((v & 1) << (w - 1)); end
        2: begin c = msb;   r = ((v << 1) | cin) & mask; end
        3: begin c = v & 1; r = (v >> 1) | (cin << (w - 1)); end
        4, 6: begin c = msb; r = (v << 1) & mask; end
        5: begin c = v & 1; r = (v >> 1) | (msb << (w - 1)); end
        default: begin c = v & 1; r = v >> 1; end
      endcase
      e.wdata = r;
      e.acc = acc;
      e.flags = (((r >> (w - 1)) & 1) << 5) | ((r == 0 ? 1 : 0) << 4) | (even_par(r) << 2) | c;
      e.we = (op == 2 || op == 3) ? 'b110101 : 'b111111;
      e.cyc = 8;
    end
    return e;
  endfunction

  function automatic string data_tag(int op);
    if (op <= 1) return "R4";
    if (op <= 3) return "R5";
    if (op <= 7) return "R6";
    if (op == 8) return "R8";
    return "R9";
  endfunction

  task automatic compare();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk("R2 valid", int'(valid_o), e.vld);
    if (e.vld == 0 || valid_o !== 1'b1) return;
    chk({data_tag(e.op), " wdata"}, int'(wdata_o), e.wdata);
    if (e.op >= 8 || e.word == 0) chk("R3 upper byte", int'(wdata_o[15:8]), 0);
    chk(e.op >= 8 ? "R10 flags" : "R7 flags", int'(flags_o), e.flags);
    chk(e.op >= 8 ? "R10 cycles" : "R7 cycles", int'(cycles_o), e.cyc);
    chk((e.op == 2 || e.op == 3) ? "R5 write enables" : "R11 write enables", int'(flag_we_o), e.we);
    chk(e.op >= 8 ? {data_tag(e.op), " acc"} : "R11 acc passthrough", int'(acc_o), e.acc);
  endtask

  task automatic step(int vld, int op, int word, int mem, int cin, int acc);
    @(negedge clk_i);
    compare();
    valid_i = vld[0]; op_i = op[3:0]; word_i = word[0];
    mem_i = mem[15:0]; carry_i = cin[0]; acc_i = acc[7:0];
    q.push_back(model(vld, op, word, mem, cin, acc));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; valid_i = 0; op_i = 0; word_i = 0; mem_i = 0; carry_i = 0; acc_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset data", int'({wdata_o, acc_o}), 0);
    chk("R1 reset flags", int'({flags_o, flag_we_o, cycles_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", int'(valid_o), 0);

    // directed corner cases
    step(1, 0, 0, 'h0081, 0, 'h00);   // R4 byte rlc wraps msb
    step(1, 1, 1, 'h0001, 0, 'h00);   // R4 word rrc
    step(1, 2, 0, 'h0080, 0, 'h00);   // R5 result zero, carry out
    step(1, 3, 1, 'h0001, 1, 'h00);   // R5 word rr carry in to msb
    step(1, 5, 0, 'h0080, 0, 'h00);   // R6 sra keeps sign
    step(1, 7, 1, 'h8001, 0, 'h00);   // R6 srl
    step(1, 4, 1, 'h8000, 1, 'h5A);   // R6 sla word to zero
    step(1, 6, 0, 'hFF7F, 1, 'h5A);   // R3 byte ignores upper bits
    step(1, 8, 0, 'h0034, 0, 'h12);   // R8
    step(1, 9, 0, 'h0034, 1, 'h12);   // R9
    step(1, 8, 1, 'hAB34, 1, 'h12);   // R10 word_i ignored
    step(1, 9, 0, 'h0000, 0, 'h00);   // R10 zero accumulator
    step(1, 12, 0, 'h1234, 0, 'h11);  // R2 illegal op
    step(0, 0, 0, 'h1234, 0, 'h11);   // R2 no request
    step(1, 15, 1, 'h1234, 1, 'h11);  // R2 illegal op

    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, $urandom % 11, $urandom % 2, $urandom % 65536,
           $urandom % 2, $urandom % 256);
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    compare();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule